// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes the four level-sensitive PCI interrupt pins (A through D, active-high here) and steers them onto a 16-line legacy interrupt controller input vector. Each pin has a 4-bit route code that names the IRQ line it drives. Every IRQ output is the OR of all pins whose route code currently selects it, so pins that share a code merge onto one line.

Three 8-bit routing registers hold the codes. They sit at byte offsets 0x55, 0x56 and 0x57 behind a plain synchronous register port. The port has an offset, write data, a write enable and a combinational read-data output. Software sets the routing through this port. After that the block is purely combinational from pin levels to IRQ outputs. It has no data stream, so no valid/ready handshake is used. All pins are plain control levels.

Top module: `pci_irq_router`

## Requirements
- R1: After reset all three routing registers hold 0x00, every IRQ output is low, and a read of any offset returns 0x00.
- R2: A write with `cfg_we` high to offset 0x55, 0x56 or 0x57 updates that register on the next rising clock edge. A read with the same offset then returns the full byte written. This includes bits [3:0] of 0x55 and 0x57, which are plain storage.
- R3: Reads of offsets other than 0x55 to 0x57 return 0x00. Writes to those offsets change no routing register and no output.
- R4: Pin A (`pin_lvl[0]`) uses bits [7:4] of register 0x55 as its route code.
- R5: Pin B (`pin_lvl[1]`) uses bits [3:0] of register 0x56. Pin C (`pin_lvl[2]`) uses bits [7:4] of register 0x56.
- R6: Pin D (`pin_lvl[3]`) uses bits [7:4] of register 0x57. Bits [3:0] of 0x55 and 0x57 have no routing effect.
- R7: Route codes 0, 2 and 15 disable a pin, so it drives nothing. `irq_out` bits 0, 2 and 15 are always low.
- R8: Each `irq_out[n]` is the OR of the levels of every pin whose route code equals n, for n a routable code.
- R9: Outputs follow pin levels in the same cycle. After a route code is rewritten, the previously selected line drops at the edge that updates the register, unless another pin still selects that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write enable, sampled at the rising edge |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| pin_lvl | input | 4 | PCI interrupt pin levels, bit 0 = A through bit 3 = D |
| irq_out | output | 16 | Legacy IRQ line levels |

## Verification
The embedded assertions check four things on every cycle:
- IRQ lines 0, 2 and 15 stay low.
- No more lines are high than there are asserted pins, and with no pin asserted every line is low.
- Each pin's decoded selection is at most one line.
- Registers change only on a matching write, and then to the written byte.

Only the bench's scenarios can show the correct nibble-to-pin mapping, the merging of pins that share a code, the immediate drop of an old line on re-routing, and the ignoring of out-of-range offsets. The bench compares every cycle against a behavioural model under directed and random traffic.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_PINS = 4;
  localparam int NUM_IRQ  = 16;
  localparam int CODE_W   = 4;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int NUM_REGS = 3;
  localparam logic [ADDR_W-1:0] REG_BASE = 8'h55;

  // Bit position of each pin's code inside the concatenated register image
  // {reg57, reg56, reg55}.
  localparam int CODE_LSB [NUM_PINS] = '{4, 8, 12, 20};

  typedef logic [CODE_W-1:0] route_code_t;

  function automatic logic code_routable(input route_code_t c);
    return (c != 4'd0) && (c != 4'd2) && (c != 4'd15);
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter logic [ADDR_W-1:0] BASE = REG_BASE
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       we,
  output logic [DATA_W-1:0]          rdata,
  output route_code_t                codes [NUM_PINS]
);
  localparam int IMG_W = NREGS * DATA_W;

  logic [DATA_W-1:0] regs_q [NREGS];
  logic [IMG_W-1:0]  image;
  logic [NREGS-1:0]  sel;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    assign sel[r] = (addr == BASE + ADDR_W'(r));
    assign image[r*DATA_W +: DATA_W] = regs_q[r];

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[r] <= '0;
      else if (we && sel[r])
        regs_q[r] <= wdata;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel[r]) |=> (regs_q[r] == $past(wdata)));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel[r]) |=> $stable(regs_q[r]));
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREGS; r++)
      if (sel[r]) rdata = regs_q[r];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_code
    assign codes[p] = image[CODE_LSB[p] +: CODE_W];
  end

  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
#(
  parameter int NIRQ = NUM_IRQ
) (
  input  logic        clk,
  input  logic        rst_n,
  input  route_code_t code,
  input  logic        level,
  output logic [NIRQ-1:0] hit
);
  logic routable;
  assign routable = code_routable(code);

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    assign hit[i] = level && routable && (code == CODE_W'(i));
  end

  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'd0 || code == 4'd2 || code == 4'd15) |-> (hit == '0));
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
  import pirq_pkg::*;
#(
  parameter int NP   = NUM_PINS,
  parameter int NIRQ = NUM_IRQ
) (
  input  logic [NIRQ-1:0] hits [NP],
  output logic [NIRQ-1:0] lines
);
  always_comb begin
    lines = '0;
    for (int p = 0; p < NP; p++)
      lines = lines | hits[p];
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                cfg_we,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic [NUM_IRQ-1:0]  irq_out
);
  route_code_t        codes [NUM_PINS];
  logic [NUM_IRQ-1:0] hits  [NUM_PINS];

  pirq_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .we    (cfg_we),
    .rdata (cfg_rdata),
    .codes (codes)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pirq_decode u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (codes[p]),
      .level (pin_lvl[p]),
      .hit   (hits[p])
    );
  end

  pirq_merge u_merge (
    .hits  (hits),
    .lines (irq_out)
  );

  a_r7_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out[0] && !irq_out[2] && !irq_out[15]);
  a_r8_no_extra_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(pin_lvl));
  a_r9_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl == '0) |-> (irq_out == '0));
endmodule

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pin_lvl = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mreg [3];
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_irq_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .pin_lvl(pin_lvl), .irq_out(irq_out)
  );

  function automatic logic [3:0] model_code(int p);
    case (p)
      0: return mreg[0][7:4];
      1: return mreg[1][3:0];
      2: return mreg[1][7:4];
      default: return mreg[2][7:4];
    endcase
  endfunction

  function automatic logic [15:0] model_irq(logic [3:0] pins);
    logic [15:0] v = '0;
    for (int n = 0; n < 16; n++)
      for (int p = 0; p < 4; p++) begin
        int c = model_code(p);
        if (pins[p] && c == n && c != 0 && c != 2 && c < 15) v[n] = 1'b1;
      end
    return v;
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a);
    if (a >= 8'h55 && a <= 8'h57) return mreg[a - 8'h55];
    return 8'h00;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare combinational outputs, then let the
  // rising edge apply any write to the model.
  task automatic step(string req, logic [7:0] a, logic [7:0] d, logic w, logic [3:0] pins);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = w; pin_lvl = pins;
    #1;
    check(req, "irq_out", irq_out, model_irq(pins));
    check(req, "rdata", {8'h00, cfg_rdata}, {8'h00, model_read(a)});
    @(posedge clk);
    if (w && rst_n && a >= 8'h55 && a <= 8'h57) mreg[a - 8'h55] = d;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 3; r++) mreg[r] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    step("R1", 8'h55, 8'h00, 0, 4'hF);
    step("R1", 8'h56, 8'h00, 0, 4'hF);
    step("R1", 8'h57, 8'h00, 0, 4'hF);
    // R2 + R6: full-byte storage incl. low nibbles
    step("R2", 8'h55, 8'hA7, 1, 4'h0);
    step("R2", 8'h55, 8'h00, 0, 4'h1);   // R4: pin A -> IRQ10
    step("R6", 8'h57, 8'h3C, 1, 4'h0);
    step("R6", 8'h57, 8'h00, 0, 4'h8);   // pin D -> IRQ3, low nibble C no effect
    step("R6", 8'h57, 8'h00, 0, 4'h7);   // low nibbles route nothing
    // R5: pins B and C
    step("R5", 8'h56, 8'h95, 1, 4'h0);
    step("R5", 8'h56, 8'h00, 0, 4'h2);   // B -> IRQ5
    step("R5", 8'h56, 8'h00, 0, 4'h4);   // C -> IRQ9
    step("R5", 8'h56, 8'h00, 0, 4'hF);
    // R3: out-of-range offsets
    step("R3", 8'h54, 8'hFF, 1, 4'hF);
    step("R3", 8'h58, 8'hFF, 1, 4'hF);
    step("R3", 8'h00, 8'h11, 1, 4'hF);
    step("R3", 8'h55, 8'h00, 0, 4'hF);
    step("R3", 8'h56, 8'h00, 0, 4'hF);
    step("R3", 8'h57, 8'h00, 0, 4'hF);
    // R8: shared codes merge
    step("R8", 8'h55, 8'hB0, 1, 4'h0);
    step("R8", 8'h56, 8'hBB, 1, 4'h0);
    step("R8", 8'h57, 8'hB0, 1, 4'h0);
    for (int m = 0; m < 16; m++) step("R8", 8'h55, 8'h00, 0, 4'(m));
    // R7: reserved codes
    step("R7", 8'h55, 8'h00, 1, 4'h0);
    step("R7", 8'h56, 8'h2F, 1, 4'h0);
    step("R7", 8'h57, 8'hF0, 1, 4'hF);
    step("R7", 8'h57, 8'h00, 0, 4'hF);
    // R9: rewrite drops the old line at the updating edge
    step("R9", 8'h55, 8'h40, 1, 4'h1);
    step("R9", 8'h55, 8'h60, 1, 4'h1);
    step("R9", 8'h55, 8'h00, 0, 4'h1);
    step("R9", 8'h56, 8'h06, 1, 4'h3);
    step("R9", 8'h55, 8'h70, 1, 4'h3);
    step("R9", 8'h55, 8'h00, 0, 4'h3);
    step("R9", 8'h55, 8'h00, 0, 4'h2);
    // Random traffic (R8, R9)
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a = 8'h53 + 8'($urandom_range(0, 6));
      step("R8", a, 8'($urandom), 1'($urandom), 4'($urandom));
    end
    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    for (int r = 0; r < 3; r++) mreg[r] = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    step("R1", 8'h56, 8'h00, 0, 4'hF);
    step("R1", 8'h57, 8'h00, 0, 4'hF);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule